// File: doc/BRIEF.md
# Configurable GPIO drive-mode controller

This block controls a small port of general-purpose pins. Each pin has three configuration bits, held in three registers that share a simple register bus: a data bit, a primary mode bit and a secondary mode bit. A decoder turns the three bits of each pin into separate enables for the pad paths: an internal pull-up path, a low-side sink path with a graded strength, and a high-side source path. It also produces a select between CMOS and TTL input thresholds. At most one path is on for any pin, so two paths can never fight.

The pad is modelled as enable outputs plus a sampled input bus. The pad inputs pass through a two-flop synchroniser before they can be read. A read of the data register returns the synchronised pad level for undriven pins and the stored data bit for driven pins. An open-drain pin is obtained by holding the data and secondary mode bits at zero and toggling only the primary mode bit. The register bus is plain control: a write takes effect at the clock edge, and a read returns its data one cycle later with a one-cycle valid pulse. The bus has no back-pressure.

Top module: `gpio_drive_port`

## Requirements
- R1: After reset, all three registers hold zero, every pull, sink and source enable is 0, sink_lvl is 00, every ttl_sel bit is 0, and a data read with the pads low returns 0.
- R2: When a pin's secondary and primary mode bits are both 0, no path is enabled. ttl_sel is 1 only when the pin's data bit is 1 in this state, and 0 for every other combination of the three bits.
- R3: With data bit 0, sink_en is 1 and the strength field (pin i at sink_lvl[2i+1:2i]) is 01 (low) for secondary=1/primary=0, 10 (medium) for secondary=0/primary=1, and 11 (high) for both 1.
- R4: With data bit 1 and primary mode bit 1, only src_en is set, whatever the secondary mode bit is.
- R5: With data bit 1, secondary mode bit 1 and primary mode bit 0, only pull_en is set.
- R6: For every pin, at most one of pull_en, sink_en and src_en is 1, and sink_en is 1 exactly when the pin's strength field is not 00.
- R7: A read of the data register (address 0x0B) returns, in bit i, the synchronised pad level if pin i has no path enabled and the stored data bit otherwise. Bits at and above NPINS read as 0.
- R8: The primary (0x0C) and secondary (0x0D) mode registers are write-only and read as all zero. Write data bits at and above NPINS are ignored.
- R9: rd_valid is 1 in exactly the cycle after a cycle with bus_rd=1, and rd_data is updated at that edge.
- R10: A change on pad_in reaches a data read only through two flops: a read sampled at the first edge after the change still sees the old level, and a read sampled at the third edge sees the new level.
- R11: With data and secondary mode bits at 0, writing the primary mode bit 1 or 0 switches the pin between medium sink and undriven.
- R12: A read and a write of the data register in the same cycle return the state from before the write. The write takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| rd_data | output | DW | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle pulse after a read |
| pad_in | input | NPINS | Sampled pad levels, asynchronous |
| pull_en | output | NPINS | Pull-up path enable per pin |
| sink_en | output | NPINS | Low-side sink enable per pin |
| sink_lvl | output | 2*NPINS | Sink strength per pin (00 none, 01 low, 10 medium, 11 high) |
| src_en | output | NPINS | High-side source enable per pin |
| ttl_sel | output | NPINS | 1 selects the TTL input threshold |

## Verification
The register write and the data readback can happen in the same cycle. When they do, the read must return the pad/data mix that the old configuration implies, while the new configuration already drives the enables one edge later. The bench issues a write and a read of the data register together, with pad levels that differ from the stored bits. It checks rd_data against a value computed from the shadow state before the write, and it checks the enables against the state after the write. The random phase also moves the pad levels while the modes change, so the choice between driven and undriven pins is tested against both sources.

// File: rtl/gpio_drive_pkg.sv
package gpio_drive_pkg;
  typedef enum logic [1:0] {
    SINK_OFF  = 2'b00,
    SINK_LOW  = 2'b01,
    SINK_MED  = 2'b10,
    SINK_HIGH = 2'b11
  } sink_lvl_e;

  typedef struct packed {
    logic      pull;
    logic      sink;
    sink_lvl_e lvl;
    logic      src;
    logic      ttl;
  } pin_ctl_t;
endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file #(
  parameter int NPINS = 2,
  parameter int AW = 4,
  parameter logic [AW-1:0] DATA_ADDR = 4'hB,
  parameter logic [AW-1:0] PRI_ADDR  = 4'hC,
  parameter logic [AW-1:0] SEC_ADDR  = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wbits,
  output logic [NPINS-1:0] data_q,
  output logic [NPINS-1:0] pri_q,
  output logic [NPINS-1:0] sec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      pri_q  <= '0;
      sec_q  <= '0;
    end else if (wr_en) begin
      if (addr == DATA_ADDR) data_q <= wbits;
      if (addr == PRI_ADDR)  pri_q  <= wbits;
      if (addr == SEC_ADDR)  sec_q  <= wbits;
    end
  end
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
  import gpio_drive_pkg::*;
(
  input  logic     data_bit,
  input  logic     sec_bit,
  input  logic     pri_bit,
  output pin_ctl_t ctl
);
  always_comb begin
    ctl = '{pull: 1'b0, sink: 1'b0, lvl: SINK_OFF, src: 1'b0, ttl: 1'b0};
    unique case ({data_bit, sec_bit, pri_bit})
      3'b000: ;
      3'b100: ctl.ttl = 1'b1;
      3'b010: begin ctl.sink = 1'b1; ctl.lvl = SINK_LOW;  end
      3'b001: begin ctl.sink = 1'b1; ctl.lvl = SINK_MED;  end
      3'b011: begin ctl.sink = 1'b1; ctl.lvl = SINK_HIGH; end
      3'b110: ctl.pull = 1'b1;
      3'b101, 3'b111: ctl.src = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_drive_port.sv
module gpio_drive_port
  import gpio_drive_pkg::*;
#(
  parameter int NPINS = 2,
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] DATA_ADDR = 4'hB,
  parameter logic [AW-1:0] PRI_ADDR  = 4'hC,
  parameter logic [AW-1:0] SEC_ADDR  = 4'hD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pull_en,
  output logic [NPINS-1:0]   sink_en,
  output logic [2*NPINS-1:0] sink_lvl,
  output logic [NPINS-1:0]   src_en,
  output logic [NPINS-1:0]   ttl_sel
);
  logic [NPINS-1:0] data_q, pri_q, sec_q, pad_s, driven;
  logic [DW-1:0]    rd_mux;
  logic             unused_hi;

  assign unused_hi = ^bus_wdata[DW-1:NPINS];

  gpio_reg_file #(
    .NPINS(NPINS), .AW(AW),
    .DATA_ADDR(DATA_ADDR), .PRI_ADDR(PRI_ADDR), .SEC_ADDR(SEC_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wbits(bus_wdata[NPINS-1:0]),
    .data_q(data_q), .pri_q(pri_q), .sec_q(sec_q)
  );

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pad_s)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_ctl_t ctl;
    gpio_pin_decode u_dec (
      .data_bit(data_q[i]), .sec_bit(sec_q[i]), .pri_bit(pri_q[i]), .ctl(ctl)
    );
    assign pull_en[i]        = ctl.pull;
    assign sink_en[i]        = ctl.sink;
    assign sink_lvl[2*i +: 2] = ctl.lvl;
    assign src_en[i]         = ctl.src;
    assign ttl_sel[i]        = ctl.ttl;
    assign driven[i]         = ctl.pull | ctl.sink | ctl.src;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == DATA_ADDR)
      rd_mux[NPINS-1:0] = (driven & data_q) | (~driven & pad_s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_drive_port_chk.sv
module gpio_drive_port_chk #(
  parameter int NPINS = 2,
  parameter int DW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_rd,
  input logic               rd_valid,
  input logic [DW-1:0]      rd_data,
  input logic [NPINS-1:0]   pull_en,
  input logic [NPINS-1:0]   sink_en,
  input logic [2*NPINS-1:0] sink_lvl,
  input logic [NPINS-1:0]   src_en,
  input logic [NPINS-1:0]   ttl_sel
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (pull_en == '0 && sink_en == '0 && src_en == '0 && ttl_sel == '0 && !rd_valid));

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_data >> NPINS) == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
    assert_single_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pull_en[i], sink_en[i], src_en[i]}));
    assert_sink_lvl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sink_en[i] == (sink_lvl[2*i +: 2] != 2'b00));
    assert_ttl_undriven_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ttl_sel[i] |-> !(pull_en[i] | sink_en[i] | src_en[i]));
  end
endmodule

bind gpio_drive_port gpio_drive_port_chk #(.NPINS(NPINS), .DW(DW)) u_chk (.*);

// File: tb/gpio_drive_port_test.sv
module gpio_drive_port_test;
  localparam int NPINS = 2;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_DATA = 4'hB;
  localparam logic [AW-1:0] A_PRI  = 4'hC;
  localparam logic [AW-1:0] A_SEC  = 4'hD;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, rd_data;
  logic rd_valid;
  logic [NPINS-1:0] pad_in = '0, pull_en, sink_en, src_en, ttl_sel;
  logic [2*NPINS-1:0] sink_lvl;

  int tests = 0, fails = 0;
  logic [NPINS-1:0] sd = '0, sp = '0, ss = '0;
  logic [DW-1:0] got;

  always #4 clk = ~clk;

  gpio_drive_port uut (.*);

  // expected {pull, sink, lvl[1:0], src, ttl}
  function automatic logic [5:0] exp_ctl(input logic d, input logic s, input logic p);
    case ({d, s, p})
      3'b100: return 6'b000001;
      3'b010: return 6'b010100;
      3'b001: return 6'b011000;
      3'b011: return 6'b011100;
      3'b110: return 6'b100000;
      3'b101, 3'b111: return 6'b000010;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [NPINS-1:0] d, input logic [NPINS-1:0] s,
                                             input logic [NPINS-1:0] p, input logic [NPINS-1:0] pad);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < NPINS; i++) begin
      logic [5:0] c = exp_ctl(d[i], s[i], p[i]);
      r[i] = (c[5] | c[4] | c[1]) ? d[i] : pad[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req);
    for (int i = 0; i < NPINS; i++) begin
      logic [5:0] a = {pull_en[i], sink_en[i], sink_lvl[2*i +: 2], src_en[i], ttl_sel[i]};
      check(req, {2'b0, a}, {2'b0, exp_ctl(sd[i], ss[i], sp[i])});
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 0;
    if (a == A_DATA) sd = v[NPINS-1:0];
    if (a == A_PRI)  sp = v[NPINS-1:0];
    if (a == A_SEC)  ss = v[NPINS-1:0];
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = rd_data;
    check("R9 rd_valid", {7'b0, rd_valid}, 8'h01);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_pins("R1 reset outputs");
    rd(A_DATA, got); check("R1 reset read", got, 8'h00);

    // R2 undriven, ttl select
    wr(A_DATA, 8'h01); check_pins("R2 ttl sel");
    pad_in = 2'b10; settle();
    rd(A_DATA, got); check("R7 undriven pad read", got, 8'h02);

    // R3 sink strengths
    wr(A_DATA, 8'h00);
    wr(A_SEC, 8'h01); wr(A_PRI, 8'h02); check_pins("R3 low/med sink");
    wr(A_SEC, 8'h03); wr(A_PRI, 8'h03); check_pins("R3 high sink");
    // R4 source, either secondary bit
    wr(A_DATA, 8'h03); wr(A_SEC, 8'h01); check_pins("R4 source");
    // R5 pull-up
    wr(A_PRI, 8'h00); wr(A_SEC, 8'h03); check_pins("R5 pull-up");
    rd(A_DATA, got); check("R7 driven read", got, exp_read(sd, ss, sp, pad_in));

    // R8 write-only modes, reserved bits ignored
    rd(A_PRI, got); check("R8 primary reads zero", got, 8'h00);
    rd(A_SEC, got); check("R8 secondary reads zero", got, 8'h00);
    wr(A_DATA, 8'hFC); check("R8 reserved ignored", {6'b0, ttl_sel}, 8'h00);
    wr(A_SEC, 8'h00);
    rd(A_DATA, got); check("R8 reserved data read", got, exp_read(sd, ss, sp, pad_in));

    // R11 open-drain toggling
    wr(A_DATA, 8'h00); wr(A_SEC, 8'h00);
    wr(A_PRI, 8'h01); check({6'b0, sink_lvl[1:0]} == 8'h02 ? "R11" : "R11 med", {6'b0, sink_lvl[1:0]}, 8'h02);
    wr(A_PRI, 8'h00); check("R11 release", {7'b0, sink_en[0] | src_en[0] | pull_en[0]}, 8'h00);

    // R10 synchroniser latency (all pins undriven now)
    pad_in = 2'b00; settle();
    @(negedge clk);
    pad_in = 2'b11; bus_rd = 1; bus_addr = A_DATA;
    @(negedge clk);
    bus_rd = 0;
    check("R10 first edge old", rd_data, 8'h00);
    settle();
    rd(A_DATA, got); check("R10 settled new", got, 8'h03);

    // R12 simultaneous read and write of data register
    wr(A_PRI, 8'h03);
    @(negedge clk);
    bus_wr = 1; bus_rd = 1; bus_addr = A_DATA; bus_wdata = 8'h02;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    check("R12 pre-write read", rd_data, exp_read(2'b00, ss, sp, pad_in));
    sd = 2'b10;
    check_pins("R12 write applied");

    // random phase
    for (int n = 0; n < 300; n++) begin
      logic [DW-1:0] vd = DW'($urandom), vs = DW'($urandom), vp = DW'($urandom);
      wr(A_DATA, vd); wr(A_SEC, vs); wr(A_PRI, vp);
      check_pins("R2-R6 random decode");
      pad_in = NPINS'($urandom); settle();
      rd(A_DATA, got); check("R7 random read", got, exp_read(sd, ss, sp, pad_in));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule